// File: doc/BRIEF.md
# Bridge Frame CRC-16 Generator

This block produces the two check bytes that close each command frame sent over a single-wire bus to an I2C bridge device. The frame builder presents the frame bytes one per clock. Each byte carries a tag that names its field: command, target address, first length, payload or second length. The block folds each byte into a reflected CRC-16 register. It starts each frame from a start strobe. A finish strobe releases the inverted register as a low byte and a high byte, together with a one-cycle done pulse.

Some fields in these frames are optional. An address byte that equals the "no address" marker takes no part in the check. A second length of zero also takes no part. The payload counts only when the frame builder sends payload bytes. Field order is the caller's responsibility. The block folds bytes in the order they arrive.

Top module: `bridge_crc16`

## Requirements
- R1: The register starts at 0x0000. Each counted byte is XORed into bits 7:0, followed by eight right shifts, and each shift XORs 0xA001 when the bit shifted out is 1. As a check value, payload bytes "123456789" (0x31..0x39) yield crc_lo_o=0xC2 and crc_hi_o=0x44.
- R2: Tag codes on in_tag_i are: 0 command, 1 target address, 2 first length, 3 payload, 4 second length. Bytes tagged 0, 2 and 3 always count, in arrival order.
- R3: A byte tagged 1 whose value is 0xFF is skipped. A byte tagged 1 with any other value, 0x00 included, counts.
- R4: A byte tagged 4 counts only when it is nonzero.
- R5: Bytes tagged 5, 6 or 7 are accepted and have no effect on the result.
- R6: The cycle after finish_i is sampled, done_o is high for exactly one cycle. In that cycle crc_lo_o carries bits 7:0 of the register XOR 0xFFFF and crc_hi_o carries bits 15:8. Both outputs keep their value until the next result.
- R7: in_ready_o is low in the done cycle, and a byte offered in that cycle is not taken.
- R8: start_i clears the register at any time and discards the partial frame. A byte or a finish_i in the same cycle as start_i is dropped, and no done pulse follows.
- R9: A byte accepted in the same cycle as finish_i counts towards that result. After a finish the register is back at 0x0000, so the next frame may begin without a start.
- R10: After reset done_o is 0, in_ready_o is 1, and both result bytes are 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a new frame, discarding any partial one |
| in_valid_i | input | 1 | Byte on in_data_i is offered |
| in_ready_o | output | 1 | Byte can be taken this cycle |
| in_tag_i | input | 3 | Field code of the offered byte |
| in_data_i | input | 8 | Offered frame byte |
| finish_i | input | 1 | Close the frame and produce the check bytes |
| done_o | output | 1 | One-cycle pulse: check bytes are new |
| crc_lo_o | output | 8 | Low byte of the inverted check value (sent first) |
| crc_hi_o | output | 8 | High byte of the inverted check value |

## Verification
The bench builds the block with its default parameters: polynomial 0xA001, seed 0x0000, output mask 0xFFFF and address marker 0xFF. With these values the results can be compared against a known CRC-16 check value, and the marker and zero-length skip rules apply exactly as the bridge frames need them. Random frames mix absent and present addresses, marker and zero addresses, zero and nonzero second lengths, and frames with and without a payload. Directed cases cover a byte in the same cycle as finish, start against finish, and a byte offered in the done cycle.

// File: rtl/bridge_crc16.sv
module bridge_crc16 #(
  parameter logic [15:0] POLY      = 16'hA001,
  parameter logic [15:0] SEED      = 16'h0000,
  parameter logic [15:0] OUT_MASK  = 16'hFFFF,
  parameter logic [7:0]  NO_ADDR   = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       in_valid_i,
  output logic       in_ready_o,
  input  logic [2:0] in_tag_i,
  input  logic [7:0] in_data_i,
  input  logic       finish_i,
  output logic       done_o,
  output logic [7:0] crc_lo_o,
  output logic [7:0] crc_hi_o
);

  localparam logic [2:0] TAG_CMD  = 3'd0;
  localparam logic [2:0] TAG_ADDR = 3'd1;
  localparam logic [2:0] TAG_LEN  = 3'd2;
  localparam logic [2:0] TAG_DATA = 3'd3;
  localparam logic [2:0] TAG_LEN2 = 3'd4;

  function automatic logic [15:0] fold(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++)
      r = r[0] ? ((r >> 1) ^ POLY) : (r >> 1);
    return r;
  endfunction

  logic [15:0] acc_q, acc_next, res_q;
  logic        done_q, take, counts;

  assign in_ready_o = !done_q;
  assign take       = in_valid_i && in_ready_o && !start_i;

  always_comb begin
    case (in_tag_i)
      TAG_CMD, TAG_LEN, TAG_DATA: counts = 1'b1;
      TAG_ADDR:                   counts = (in_data_i != NO_ADDR);
      TAG_LEN2:                   counts = (in_data_i != 8'h00);
      default:                    counts = 1'b0;
    endcase
  end

  assign acc_next = (take && counts) ? fold(acc_q, in_data_i) : acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= SEED;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        acc_q <= SEED;
      end else if (finish_i) begin
        res_q  <= acc_next ^ OUT_MASK;
        done_q <= 1'b1;
        acc_q  <= SEED;
      end else begin
        acc_q <= acc_next;
      end
    end
  end

  assign done_o   = done_q;
  assign crc_lo_o = res_q[7:0];
  assign crc_hi_o = res_q[15:8];

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r6_done_follows_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (finish_i && !start_i) |=> done_o);
  a_r6_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!finish_i || start_i) |=> $stable({crc_hi_o, crc_lo_o}));
  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (acc_q == SEED) && !done_o);
  a_r3_marker_skipped: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o && in_tag_i == TAG_ADDR && in_data_i == NO_ADDR
     && !start_i && !finish_i) |=> $stable(acc_q));
  a_r7_no_take_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i && !finish_i) |=> acc_q == $past(acc_q));

endmodule

// File: tb/tb_bridge_crc16.sv
`timescale 1ns/1ps
module tb_bridge_crc16;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, in_valid_i = 1'b0, finish_i = 1'b0;
  logic [2:0] in_tag_i = '0;
  logic [7:0] in_data_i = '0;
  logic       in_ready_o, done_o;
  logic [7:0] crc_lo_o, crc_hi_o;

  int checks = 0, fails = 0;
  logic [15:0] model = 16'h0000;
  logic [15:0] last_res = 16'h0000;

  always #2.5 clk = ~clk;

  bridge_crc16 dut (.clk(clk), .rst_n(rst_n), .start_i(start_i), .in_valid_i(in_valid_i),
    .in_ready_o(in_ready_o), .in_tag_i(in_tag_i), .in_data_i(in_data_i), .finish_i(finish_i),
    .done_o(done_o), .crc_lo_o(crc_lo_o), .crc_hi_o(crc_hi_o));

  function automatic logic [15:0] m_fold(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction

  function automatic logic [15:0] m_take(input logic [15:0] c, input logic [2:0] t, input logic [7:0] d);
    if (t == 3'd0 || t == 3'd2 || t == 3'd3) return m_fold(c, d);
    if (t == 3'd1) return (d == 8'hFF) ? c : m_fold(c, d);
    if (t == 3'd4) return (d == 8'h00) ? c : m_fold(c, d);
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input logic [2:0] t, input logic [7:0] d);
    @(negedge clk);
    in_valid_i = 1'b1; in_tag_i = t; in_data_i = d;
    model = m_take(model, t, d);
    @(negedge clk);
    in_valid_i = 1'b0;
  endtask

  task automatic fin(input string req);
    logic [15:0] e;
    e = model ^ 16'hFFFF;
    @(negedge clk);
    finish_i = 1'b1;
    @(negedge clk);
    finish_i = 1'b0;
    chk(done_o === 1'b1, "R6 done pulse", {31'd0, done_o}, 32'd1);
    chk({crc_hi_o, crc_lo_o} === e, req, {16'd0, crc_hi_o, crc_lo_o}, {16'd0, e});
    last_res = e;
    model = 16'h0000;
    @(negedge clk);
    chk(done_o === 1'b0, "R6 done width", {31'd0, done_o}, 32'd0);
    chk({crc_hi_o, crc_lo_o} === e, "R6 result holds", {16'd0, crc_hi_o, crc_lo_o}, {16'd0, e});
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed_set;
    seed_set = $urandom(32'h0C2C_4416);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk(done_o === 1'b0 && in_ready_o === 1'b1, "R10 flags", {30'd0, done_o, in_ready_o}, 32'd1);
    chk({crc_hi_o, crc_lo_o} === 16'h0000, "R10 result", {16'd0, crc_hi_o, crc_lo_o}, 32'd0);

    // R1 check value
    for (int i = 0; i < 9; i++) put(3'd3, 8'h31 + 8'(i));
    fin("R1 check value");
    chk(crc_lo_o === 8'hC2 && crc_hi_o === 8'h44, "R1 known bytes", {16'd0, crc_hi_o, crc_lo_o}, 32'h44C2);

    // R2 full frame in order
    put(3'd0, 8'h87); put(3'd1, 8'h52); put(3'd2, 8'h02); put(3'd3, 8'hA5); put(3'd3, 8'h5A); put(3'd4, 8'h03);
    fin("R2 full frame");

    // R3 marker skipped vs zero address counted
    put(3'd0, 8'h55); put(3'd1, 8'hFF); put(3'd2, 8'h01); put(3'd3, 8'h10);
    fin("R3 marker address skipped");
    put(3'd0, 8'h55); put(3'd1, 8'h00); put(3'd2, 8'h01); put(3'd3, 8'h10);
    fin("R3 zero address counted");

    // R4 zero second length
    put(3'd0, 8'h2D); put(3'd1, 8'hA0); put(3'd2, 8'h01); put(3'd3, 8'h00); put(3'd4, 8'h00);
    fin("R4 zero second length skipped");

    // R5 unused tags
    put(3'd0, 8'hE1); put(3'd5, 8'h12); put(3'd6, 8'h34); put(3'd7, 8'h56); put(3'd2, 8'h04);
    fin("R5 unused tags ignored");

    // R7 byte offered in done cycle is refused
    @(negedge clk); finish_i = 1'b1;
    @(negedge clk); finish_i = 1'b0;
    in_valid_i = 1'b1; in_tag_i = 3'd3; in_data_i = 8'h99;
    chk(in_ready_o === 1'b0, "R7 ready low in done cycle", {31'd0, in_ready_o}, 32'd0);
    @(negedge clk); in_valid_i = 1'b0;
    model = 16'h0000;
    fin("R7 refused byte not counted");

    // R8 start discards, drops same-cycle byte
    put(3'd0, 8'h11); put(3'd3, 8'h22);
    @(negedge clk); start_i = 1'b1; in_valid_i = 1'b1; in_tag_i = 3'd0; in_data_i = 8'h77;
    @(negedge clk); start_i = 1'b0; in_valid_i = 1'b0;
    model = 16'h0000;
    put(3'd0, 8'h4B);
    fin("R8 start discards partial frame");
    // R8 start wins over finish
    put(3'd0, 8'h3C);
    @(negedge clk); start_i = 1'b1; finish_i = 1'b1;
    @(negedge clk); start_i = 1'b0; finish_i = 1'b0;
    model = 16'h0000;
    chk(done_o === 1'b0, "R8 no done with start", {31'd0, done_o}, 32'd0);
    chk({crc_hi_o, crc_lo_o} === last_res, "R8 result kept", {16'd0, crc_hi_o, crc_lo_o}, {16'd0, last_res});

    // R9 byte with finish counts, next frame without start
    put(3'd0, 8'hC3);
    @(negedge clk); finish_i = 1'b1; in_valid_i = 1'b1; in_tag_i = 3'd2; in_data_i = 8'h08;
    model = m_take(model, 3'd2, 8'h08);
    @(negedge clk); finish_i = 1'b0; in_valid_i = 1'b0;
    chk(done_o === 1'b1 && {crc_hi_o, crc_lo_o} === (model ^ 16'hFFFF), "R9 same-cycle byte",
        {16'd0, crc_hi_o, crc_lo_o}, {16'd0, model ^ 16'hFFFF});
    model = 16'h0000;
    put(3'd0, 8'h69);
    fin("R9 next frame without start");

    // Random frames (R2 R3 R4)
    for (int f = 0; f < 60; f++) begin
      int n;
      put(3'd0, 8'($urandom));
      case ($urandom % 3)
        0: ;
        1: put(3'd1, 8'hFF);
        default: put(3'd1, 8'($urandom));
      endcase
      n = 1 + ($urandom % 8);
      put(3'd2, 8'(n));
      if ($urandom % 4 != 0)
        for (int k = 0; k < n; k++) put(3'd3, 8'($urandom));
      if ($urandom % 2 == 0) put(3'd4, 8'h00);
      else if ($urandom % 2 == 0) put(3'd4, 8'($urandom % 256));
      fin("R2 random frame");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule